// File: doc/BRIEF.md
# Outbound Doorbell Request Engine

This block takes short doorbell requests that software writes through a small register port. It turns each request into an outbound packet descriptor, then waits for a reply on behalf of that descriptor. Each write to the data register carries a 16-bit destination identifier and a 16-bit information word. The priority that goes with it is taken from a separate control register. Accepted requests enter a staging queue, move into a transmit queue, and are issued one at a time on a valid/ready descriptor output. Every descriptor uses the doorbell type code 10 and carries a 4-bit transaction tag.

Each issued request is copied into a pending table indexed by its tag. When a response arrives with a matching tag, the stored copy is returned on a completion output together with the error flag from the response. Each pending entry is aged against one shared free-running counter and a time-out value sampled from a register when the entry was sent. If the age reaches that value first, the stored copy is returned with a time-out flag instead. Either way the entry is released and reported once only. The two queues share one occupancy limit, and the write port stalls a data write while that limit is reached.

The issue state machine has two states. `ST_IDLE` moves to `ST_SEND` on the launch transition, which needs the transmit queue to be non-empty and a free tag; the head of the queue is then loaded into the descriptor register. `ST_SEND` returns to `ST_IDLE` on the handshake transition, when the consumer raises `pkt_ready`, and the pending entry is written at that same edge.

Top module: `dbe_engine`

## Requirements
- R1: After reset, `reg_waitreq`, `pkt_valid` and `cpl_valid` are low. Register offset 2 reads fill 0, offset 3 reads the reset time-out value (200 in the bench configuration), and offset 0 reads priority 0.
- R2: A write to offset 1 queues a request with destination `reg_wdata[31:16]` and information `reg_wdata[15:0]`. The priority is the value of control register offset 0 bits [1:0] at the time of the write. Its descriptor shows these fields with `pkt_ftype` = 10.
- R3: Descriptors leave in the order in which their data writes were accepted.
- R4: The staging and transmit queues together hold at most 16 requests. A data write made while they hold 16 keeps `reg_waitreq` high and is accepted on the first edge after space frees up.
- R5: A read of offset 2 returns the combined queue fill in bits [4:0]. Offsets 0 and 3 read back the priority and time-out registers. Reads never stall.
- R6: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and every descriptor field stays unchanged.
- R7: Each descriptor takes the lowest-numbered tag not in use. No descriptor is offered while all 16 tags are pending.
- R8: A response whose tag is pending produces a one-cycle `cpl_valid` on the next edge. It carries that tag, the stored priority, destination and information, `cpl_err` equal to `rsp_err`, and `cpl_timeout` = 0. The tag is then free.
- R9: A response whose tag is not pending produces no completion. This includes a tag that has already timed out.
- R10: A pending entry with no response is completed with `cpl_timeout` = 1 and `cpl_err` = 0. The completion is registered on the T-th clock edge after the handshake edge, where T is the offset 3 value at that handshake.
- R11: Time-out latency stays exact when the free-running counter wraps between send and expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 fill, 3 time-out |
| reg_wr | input | 1 | Register write strobe, held until `reg_waitreq` is low |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, zero-latency (data register reads 0) |
| reg_waitreq | output | 1 | Stall of a data write while the queues are at their limit |
| pkt_valid | output | 1 | Descriptor valid |
| pkt_ready | input | 1 | Descriptor accepted by the consumer |
| pkt_ftype | output | 4 | Packet type code, always 10 |
| pkt_prio | output | 2 | Descriptor priority |
| pkt_dest | output | 16 | Descriptor destination identifier |
| pkt_info | output | 16 | Descriptor information word |
| pkt_tag | output | 4 | Transaction tag |
| rsp_valid | input | 1 | Response strobe |
| rsp_tag | input | 4 | Tag of the response |
| rsp_err | input | 1 | Error flag carried by the response |
| cpl_valid | output | 1 | Completion strobe, one cycle |
| cpl_tag | output | 4 | Tag of the completed entry |
| cpl_prio | output | 2 | Stored priority |
| cpl_dest | output | 16 | Stored destination identifier |
| cpl_info | output | 16 | Stored information word |
| cpl_err | output | 1 | Error flag from the response |
| cpl_timeout | output | 1 | Entry completed by time-out |

## Verification
On every cycle the assertions check these invariants:
- the combined fill never passes its limit, and neither queue is pushed while full or popped while empty;
- a stalled descriptor stays valid and unchanged;
- a tag is only allocated while free, and a completed tag is left free;
- a stray response never yields a completion;
- a time-out completion is only reported once the entry's age has reached its stored limit.

Other behaviour only the bench scenarios can show: field mapping and priority capture, issue order, the exact number of accepted writes before the stall, when the stall releases, the lowest-free tag choice under exhaustion, the exact time-out latency, and correct aging across a counter wrap.

// File: rtl/dbe_pkg.sv
package dbe_pkg;

    localparam logic [3:0] FTYPE_DOORBELL = 4'd10;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_FILL = 2'd2,
        REG_TMO  = 2'd3
    } reg_sel_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RESP = 2'd1,
        SRC_TMO  = 2'd2
    } cpl_src_e;

endpackage

// File: rtl/dbe_fifo.sv
module dbe_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= din;
    end

    assign dout  = mem_q[rp_q];
    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    // R4
    fifo_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q != CW'(DEPTH)));

    // R3
    fifo_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

endmodule

// File: rtl/dbe_pend.sv
module dbe_pend
    import dbe_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int PAY_W = 34,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [PAY_W-1:0] alloc_data,
    input  logic [CNT_W-1:0] alloc_lim,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic             rsp_err,
    output logic             tag_avail,
    output logic [TAG_W-1:0] free_tag,
    output logic             cpl_valid,
    output logic [TAG_W-1:0] cpl_tag,
    output logic [PAY_W-1:0] cpl_data,
    output logic             cpl_err,
    output logic             cpl_timeout
);
    localparam int NTAG = 1 << TAG_W;

    logic [NTAG-1:0]  used_q;
    logic [NTAG-1:0]  expired;
    logic [PAY_W-1:0] data_q  [NTAG];
    logic [CNT_W-1:0] start_q [NTAG];
    logic [CNT_W-1:0] lim_q   [NTAG];
    logic [TAG_W-1:0] tmo_tag, rel_tag;
    logic             rsp_hit;
    cpl_src_e         src;

    // Age of each entry is a modular difference, so counter wrap is harmless.
    generate
        for (genvar g = 0; g < NTAG; g++) begin : g_age
            logic [CNT_W-1:0] age;
            assign age        = now - start_q[g];
            assign expired[g] = used_q[g] && (age >= lim_q[g]);
        end
    endgenerate

    always_comb begin
        tmo_tag   = '0;
        free_tag  = '0;
        tag_avail = 1'b0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (expired[i]) tmo_tag = TAG_W'(i);
            if (!used_q[i]) begin
                free_tag  = TAG_W'(i);
                tag_avail = 1'b1;
            end
        end
    end

    assign rsp_hit = rsp_valid && used_q[rsp_tag];

    // A matched response outranks a time-out; a missed expiry waits a cycle.
    always_comb begin
        if (rsp_hit) begin
            src     = SRC_RESP;
            rel_tag = rsp_tag;
        end else if (|expired) begin
            src     = SRC_TMO;
            rel_tag = tmo_tag;
        end else begin
            src     = SRC_NONE;
            rel_tag = tmo_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
        end else begin
            if (alloc_en)         used_q[alloc_tag] <= 1'b1;
            if (src != SRC_NONE)  used_q[rel_tag]   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            data_q[alloc_tag]  <= alloc_data;
            start_q[alloc_tag] <= now;
            lim_q[alloc_tag]   <= alloc_lim;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpl_valid   <= 1'b0;
            cpl_tag     <= '0;
            cpl_data    <= '0;
            cpl_err     <= 1'b0;
            cpl_timeout <= 1'b0;
        end else begin
            cpl_valid <= (src != SRC_NONE);
            if (src != SRC_NONE) begin
                cpl_tag     <= rel_tag;
                cpl_data    <= data_q[rel_tag];
                cpl_err     <= (src == SRC_RESP) && rsp_err;
                cpl_timeout <= (src == SRC_TMO);
            end
        end
    end

    logic [CNT_W-1:0] chk_age;
    assign chk_age = now - start_q[cpl_tag] - 1'b1;

    // R7
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !used_q[alloc_tag]);

    // R8
    cpl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !used_q[cpl_tag]);

    // R9
    stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !used_q[rsp_tag] && !(|expired)) |=> !cpl_valid);

    // R10
    tmo_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_timeout) |-> (chk_age >= lim_q[cpl_tag]));

endmodule

// File: rtl/dbe_engine.sv
module dbe_engine
    import dbe_pkg::*;
#(
    parameter int PRIO_W    = 2,
    parameter int DEST_W    = 16,
    parameter int INFO_W    = 16,
    parameter int TAG_W     = 4,
    parameter int QLIMIT    = 16,
    parameter int CNT_W     = 16,
    parameter int TMO_RESET = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               reg_addr,
    input  logic                     reg_wr,
    input  logic [DEST_W+INFO_W-1:0] reg_wdata,
    output logic [DEST_W+INFO_W-1:0] reg_rdata,
    output logic                     reg_waitreq,
    output logic                     pkt_valid,
    input  logic                     pkt_ready,
    output logic [3:0]               pkt_ftype,
    output logic [PRIO_W-1:0]        pkt_prio,
    output logic [DEST_W-1:0]        pkt_dest,
    output logic [INFO_W-1:0]        pkt_info,
    output logic [TAG_W-1:0]         pkt_tag,
    input  logic                     rsp_valid,
    input  logic [TAG_W-1:0]         rsp_tag,
    input  logic                     rsp_err,
    output logic                     cpl_valid,
    output logic [TAG_W-1:0]         cpl_tag,
    output logic [PRIO_W-1:0]        cpl_prio,
    output logic [DEST_W-1:0]        cpl_dest,
    output logic [INFO_W-1:0]        cpl_info,
    output logic                     cpl_err,
    output logic                     cpl_timeout
);
    localparam int REG_W  = DEST_W + INFO_W;
    localparam int REQ_W  = PRIO_W + DEST_W + INFO_W;
    localparam int FILL_W = $clog2(QLIMIT + 1);

    reg_sel_e          sel;
    logic [PRIO_W-1:0] prio_q;
    logic [CNT_W-1:0]  tmo_q;
    logic [CNT_W-1:0]  now_q;
    logic              data_wr, push_stg, move, launch, handshake;
    logic [REQ_W-1:0]  stg_dout, tx_dout, cpl_word;
    logic [FILL_W-1:0] stg_cnt, tx_cnt, fill;
    logic              stg_empty, stg_full, tx_empty, tx_full;
    logic              tag_avail;
    logic [TAG_W-1:0]  free_tag;
    tx_state_e         st_q, st_d;

    assign sel         = reg_sel_e'(reg_addr);
    assign data_wr     = reg_wr && (sel == REG_DATA);
    assign fill        = stg_cnt + tx_cnt;
    assign reg_waitreq = data_wr && (fill == FILL_W'(QLIMIT));
    assign push_stg    = data_wr && !reg_waitreq;
    assign move        = !stg_empty && !tx_full;

    // Register file: priority and time-out value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            tmo_q  <= CNT_W'(TMO_RESET);
        end else if (reg_wr) begin
            if (sel == REG_CTRL) prio_q <= reg_wdata[PRIO_W-1:0];
            if (sel == REG_TMO)  tmo_q  <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        unique case (sel)
            REG_CTRL: reg_rdata = REG_W'(prio_q);
            REG_DATA: reg_rdata = '0;
            REG_FILL: reg_rdata = REG_W'(fill);
            REG_TMO:  reg_rdata = REG_W'(tmo_q);
        endcase
    end

    // Shared free-running time base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    dbe_fifo #(.W(REQ_W), .DEPTH(QLIMIT)) stg_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(push_stg), .din({prio_q, reg_wdata}),
        .pop(move), .dout(stg_dout),
        .count(stg_cnt), .empty(stg_empty), .full(stg_full)
    );

    dbe_fifo #(.W(REQ_W), .DEPTH(QLIMIT)) tx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(move), .din(stg_dout),
        .pop(launch), .dout(tx_dout),
        .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    // Issue state machine
    assign launch    = (st_q == ST_IDLE) && !tx_empty && tag_avail;
    assign handshake = (st_q == ST_SEND) && pkt_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (launch)    st_d = ST_SEND;
            ST_SEND: if (pkt_ready) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_prio <= '0;
            pkt_dest <= '0;
            pkt_info <= '0;
            pkt_tag  <= '0;
        end else if (launch) begin
            {pkt_prio, pkt_dest, pkt_info} <= tx_dout;
            pkt_tag <= free_tag;
        end
    end

    assign pkt_valid = (st_q == ST_SEND);
    assign pkt_ftype = FTYPE_DOORBELL;

    dbe_pend #(.TAG_W(TAG_W), .PAY_W(REQ_W), .CNT_W(CNT_W)) pend_i (
        .clk(clk), .rst_n(rst_n), .now(now_q),
        .alloc_en(handshake), .alloc_tag(pkt_tag),
        .alloc_data({pkt_prio, pkt_dest, pkt_info}), .alloc_lim(tmo_q),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_err(rsp_err),
        .tag_avail(tag_avail), .free_tag(free_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_word),
        .cpl_err(cpl_err), .cpl_timeout(cpl_timeout)
    );

    assign {cpl_prio, cpl_dest, cpl_info} = cpl_word;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(QLIMIT));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_prio) &&
            $stable(pkt_dest) && $stable(pkt_info) && $stable(pkt_tag)));

    // R7
    tag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> $past(tag_avail));

endmodule

// File: tb/dbe_engine_tb_top.sv
module dbe_engine_tb_top;

    localparam int T_RST = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_waitreq;
    logic        pkt_valid;
    logic        pkt_ready = 1'b1;
    logic [3:0]  pkt_ftype;
    logic [1:0]  pkt_prio;
    logic [15:0] pkt_dest, pkt_info;
    logic [3:0]  pkt_tag;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_tag = '0;
    logic        rsp_err = 1'b0;
    logic        cpl_valid;
    logic [3:0]  cpl_tag;
    logic [1:0]  cpl_prio;
    logic [15:0] cpl_dest, cpl_info;
    logic        cpl_err, cpl_timeout;

    int n_chk = 0;
    int n_bad = 0;

    // {rsp_err, prio, dest, info}
    localparam logic [34:0] VEC [0:5] = '{
        {1'b0, 2'd0, 16'h0001, 16'h0000},
        {1'b1, 2'd3, 16'hFFFF, 16'hFFFF},
        {1'b0, 2'd1, 16'hA5A5, 16'h5A5A},
        {1'b1, 2'd2, 16'h1234, 16'hBEEF},
        {1'b0, 2'd3, 16'h0000, 16'h8001},
        {1'b0, 2'd1, 16'h7F00, 16'h00FF}
    };

    dbe_engine #(.CNT_W(8), .TMO_RESET(T_RST)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_waitreq(reg_waitreq),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_ftype(pkt_ftype),
        .pkt_prio(pkt_prio), .pkt_dest(pkt_dest), .pkt_info(pkt_info), .pkt_tag(pkt_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_err(rsp_err),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_prio(cpl_prio),
        .cpl_dest(cpl_dest), .cpl_info(cpl_info), .cpl_err(cpl_err),
        .cpl_timeout(cpl_timeout)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d, output int stalls);
        logic w;
        stalls = 0;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        forever begin
            #1 w = reg_waitreq;
            @(negedge clk);
            if (!w) break;
            stalls++;
        end
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Returns at a negedge with a valid descriptor present.
    task automatic wait_pkt(output logic ok);
        ok = 1'b0;
        for (int n = 0; n < 300; n++) begin
            if (pkt_valid) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic send_rsp(input logic [3:0] t, input logic e);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_tag = t; rsp_err = e;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int st;
        logic ok;
        logic [31:0] rd;
        logic [3:0] tg;
        logic [3:0] tags [0:15];
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 waitreq", reg_waitreq, 0);
        chk("R1 pkt_valid", pkt_valid, 0);
        chk("R1 cpl_valid", cpl_valid, 0);
        reg_read(2'd2, rd); chk("R1 fill", rd, 0);
        reg_read(2'd3, rd); chk("R1 timeout", rd, T_RST);
        reg_read(2'd0, rd); chk("R1 prio", rd, 0);

        // R2 / R8 vector table
        for (int i = 0; i < 6; i++) begin
            reg_write(2'd0, {30'd0, VEC[i][33:32]}, st);
            reg_read(2'd0, rd); chk("R5 prio readback", rd, VEC[i][33:32]);
            reg_write(2'd1, VEC[i][31:0], st);
            wait_pkt(ok);
            chk("R2 valid", ok, 1);
            chk("R2 ftype", pkt_ftype, 10);
            chk("R2 prio", pkt_prio, VEC[i][33:32]);
            chk("R2 dest", pkt_dest, VEC[i][31:16]);
            chk("R2 info", pkt_info, VEC[i][15:0]);
            chk("R7 lowest tag", pkt_tag, 0);
            tg = pkt_tag;
            send_rsp(tg, VEC[i][34]);
            chk("R8 cpl_valid", cpl_valid, 1);
            chk("R8 cpl_tag", cpl_tag, tg);
            chk("R8 cpl_fields", {cpl_prio, cpl_dest, cpl_info}, VEC[i][33:0]);
            chk("R8 cpl_err", cpl_err, VEC[i][34]);
            chk("R8 cpl_timeout", cpl_timeout, 0);
        end

        // R9 response for a tag never issued
        send_rsp(4'd9, 1'b0);
        chk("R9 stray rsp", cpl_valid, 0);

        // R10 exact time-out latency, then late response ignored
        reg_write(2'd3, 32'd30, st);
        reg_write(2'd1, 32'h4444_0030, st);
        wait_pkt(ok);
        tg = pkt_tag;
        n = 0;
        do begin @(negedge clk); n++; end while (!cpl_valid && n < 400);
        chk("R10 latency", n, 31);
        chk("R10 timeout flag", cpl_timeout, 1);
        chk("R10 err flag", cpl_err, 0);
        chk("R10 tag", cpl_tag, tg);
        chk("R10 info", cpl_info, 16'h0030);
        send_rsp(tg, 1'b0);
        chk("R9 late rsp", cpl_valid, 0);

        // R11 time-outs across counter wrap (8-bit time base)
        reg_write(2'd3, 32'd100, st);
        for (int k = 0; k < 4; k++) begin
            reg_write(2'd1, {16'h5500, 16'(k)}, st);
            wait_pkt(ok);
            n = 0;
            do begin @(negedge clk); n++; end while (!cpl_valid && n < 400);
            chk("R11 wrap latency", n, 101);
            chk("R11 wrap flag", cpl_timeout, 1);
            chk("R11 wrap info", cpl_info, 16'(k));
        end

        // R4 / R5 / R6 / R3 shared limit with a blocked consumer
        reg_write(2'd3, 32'd250, st);
        reg_write(2'd0, 32'd2, st);
        pkt_ready = 1'b0;
        for (int i = 0; i < 17; i++) begin
            reg_write(2'd1, {16'(16'h0100 + i), 16'(16'hC000 + i)}, st);
            chk("R4 no stall below limit", st, 0);
        end
        reg_read(2'd2, rd); chk("R5 fill at limit", rd, 16);
        chk("R6 held valid", pkt_valid, 1);
        chk("R6 held dest", pkt_dest, 16'h0100);
        fork
            begin
                reg_write(2'd1, {16'h0111, 16'hC011}, st);
            end
            begin
                repeat (6) @(negedge clk);
                #1 chk("R4 waitreq at limit", reg_waitreq, 1);
                chk("R6 still held", pkt_dest, 16'h0100);
                @(negedge clk);
                pkt_ready = 1'b1;
                @(negedge clk);
                pkt_ready = 1'b0;
            end
        join
        chk("R4 stall then accept", (st >= 6 && st <= 10), 1);
        send_rsp(4'd0, 1'b0);
        chk("R8 first after stall", cpl_dest, 16'h0100);
        pkt_ready = 1'b1;
        for (int i = 1; i < 18; i++) begin
            wait_pkt(ok);
            chk("R3 order", pkt_dest, 16'(16'h0100 + i));
            chk("R2 prio captured", pkt_prio, 2);
            tg = pkt_tag;
            send_rsp(tg, 1'b0);
            chk("R8 drain cpl", {cpl_valid, cpl_tag, cpl_info}, {1'b1, tg, 16'(16'hC000 + i)});
        end
        reg_read(2'd2, rd); chk("R5 fill empty", rd, 0);

        // R7 tag exhaustion
        for (int i = 0; i < 16; i++) begin
            reg_write(2'd1, {16'h0200, 16'(i)}, st);
            wait_pkt(ok);
            chk("R7 tag order", pkt_tag, i);
            tags[i] = pkt_tag;
        end
        reg_write(2'd1, {16'h0200, 16'h00AA}, st);
        n = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (pkt_valid) n++;
        end
        chk("R7 no issue when tags used", n, 0);
        send_rsp(4'd5, 1'b1);
        chk("R8 freed tag 5", {cpl_valid, cpl_tag, cpl_err, cpl_info}, {1'b1, 4'd5, 1'b1, 16'd5});
        wait_pkt(ok);
        chk("R7 reuse lowest free", pkt_tag, 5);
        chk("R7 reuse info", pkt_info, 16'h00AA);
        for (int i = 0; i < 16; i++) begin
            send_rsp(tags[i], 1'b0);
            chk("R8 release all", {cpl_valid, cpl_tag}, {1'b1, tags[i]});
        end

        summary();
    end

endmodule